// File: doc/BRIEF.md
# Converter Serial Output Port Model

This block models the digital side of a successive-approximation converter with a two-wire serial read port. It can serve as a device under test or as a stand-in peripheral next to a controller that expects such a converter. A falling edge on the active-low convert-start input puts the sampler into hold, captures the sample word, and asserts busy for a programmable number of system clock cycles. When that time runs out, busy drops and the captured value is loaded into the output register. No analog conversion is modelled: the value on `sample_i` at the hold instant is taken as the result.

The result is read with an external serial clock. The first bit is driven after the first serial clock rising edge, and each later bit is driven after a falling edge. The output word is 16 bits: four zeros, then the 12-bit result with the most significant bit first. After the sixteenth falling edge the output stops being driven. Extra clocks start the word again, and in that case the line stays driven until the next reset. The bit position is cleared only by a convert-start falling edge that arrives while the serial clock is low.

If convert-start is still low when a conversion ends, the model goes to sleep. The next rising edge of convert-start starts a programmable wake period, and the hold is delayed until that period has ended. Both asynchronous inputs pass through two-flop synchronisers, so the system clock must run at least four times faster than the serial clock.

Top module: `adc_serial_port_model`

## Requirements
- R1: After reset, busy, sleep, output enable and serial data are all 0.
- R2: A convert-start falling edge seen while idle raises `busy_o` on the third system clock edge after the input changes. `busy_o` then stays high for exactly CONV_CYCLES cycles.
- R3: The output word is {4'b0000, sample}, sent MSB first. The sample is the value `sample_i` holds at the hold instant, and it is loaded into the output register when busy drops.
- R4: The first serial clock rising edge after a position reset raises `sdo_oe_o` and drives word bit 15. The k-th falling edge (k = 1 to 15) drives word bit 15-k.
- R5: On the sixteenth falling edge of the first pass, `sdo_oe_o` drops. While `sdo_oe_o` is 0, `sdo_o` is 0.
- R6: Clocks after the sixteenth restart the word from bit 15. Once the word has wrapped, `sdo_oe_o` stays 1 at every later sixteenth edge and after the clock stops.
- R7: A convert-start falling edge while `sclk_i` is low clears the bit position and drops `sdo_oe_o`. A falling edge while `sclk_i` is high leaves the position and the enable unchanged.
- R8: If convert-start is low when a conversion ends, `sleep_o` rises in the same cycle that `busy_o` falls. If it is high, `sleep_o` stays 0.
- R9: While asleep, a rising edge of convert-start clears `sleep_o` and starts a WAKE_CYCLES wake period. If convert-start falls during that period, busy rises with the fall and the conversion starts when the period ends. `busy_o` falls WAKE_CYCLES + CONV_CYCLES + 3 cycles after the rising input changes.
- R10: If convert-start is still high when the wake period ends, the model goes to idle. A later fall then converts with the same timing as R2.
- R11: The output word can be read in full while `sleep_o` is 1.
- R12: A convert-start falling edge during an active conversion is ignored. Busy keeps its original length of CONV_CYCLES cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnv_i | input | 1 | Convert-start, asynchronous; a falling edge starts a conversion |
| sclk_i | input | 1 | External serial clock, asynchronous |
| sample_i | input | SAMPLE_W | Value taken as the conversion result |
| busy_o | output | 1 | High while a conversion is pending or running |
| sdo_o | output | 1 | Serial data; 0 when not driven |
| sdo_oe_o | output | 1 | Serial data output enable (0 = high impedance) |
| sleep_o | output | 1 | High while the model is asleep |

## Verification
The bench sweeps sixty-four sample values across the full 12-bit range, from all zeros to all ones. For each value it measures the busy length cycle by cycle and shifts out the complete word. An off-by-one in the bit index or in the leading zeros shows up as a wrong bit, and a counter off by one shows up as a wrong busy length.

The other checks cover the cases most likely to be got wrong:
- **Wrap.** A pass past the sixteenth edge must keep the line driven. A design that tri-states again would drop the enable.
- **Position reset with the serial clock high.** A convert-start fall at that moment must leave a half-read word intact. A design that resets anyway would lose the enable in mid-word.
- **Second fall during a conversion.** A design that restarts on it would stretch busy.
- **Sleep, wake and long-pulse paths.** These are timed end to end, so a wake timer that starts at the wrong edge or a hold that skips the wake period shows up as a wrong cycle count.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CONV,
    ST_SLEEP,
    ST_WAKE
  } ctrl_state_e;
endpackage

// File: rtl/adc_port_sync.sv
module adc_port_sync #(
  parameter int WIDTH = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_lane
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RESET_VAL[g];
        sync_q <= RESET_VAL[g];
        prev_q <= RESET_VAL[g];
      end else begin
        meta_q <= async_i[g];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign level_o[g] = sync_q;
    assign rise_o[g]  = sync_q & ~prev_q;
    assign fall_o[g]  = ~sync_q & prev_q;
  end
endmodule

// File: rtl/adc_port_ctrl.sv
module adc_port_ctrl
  import adc_port_pkg::*;
#(
  parameter int SAMPLE_W    = 12,
  parameter int CONV_CYCLES = 380,
  parameter int WAKE_CYCLES = 600
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cnv_lvl_i,
  input  logic                cnv_rise_i,
  input  logic                cnv_fall_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                busy_o,
  output logic                sleep_o,
  output logic                load_o,
  output logic [SAMPLE_W-1:0] held_o
);
  localparam int MAX_CYC = (CONV_CYCLES > WAKE_CYCLES) ? CONV_CYCLES : WAKE_CYCLES;
  localparam int CW      = $clog2(MAX_CYC + 1);
  localparam logic [CW-1:0] CONV_LAST = CW'(CONV_CYCLES - 1);
  localparam logic [CW-1:0] WAKE_LAST = CW'(WAKE_CYCLES - 1);

  ctrl_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          hold_now;
  logic          tmo;

  assign tmo = (cnt_q == '0);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    pend_d   = pend_q;
    hold_now = 1'b0;
    unique case (state_q)
      ST_IDLE: if (cnv_fall_i) begin
        state_d  = ST_CONV;
        cnt_d    = CONV_LAST;
        hold_now = 1'b1;
      end
      ST_CONV: begin
        // falls here are ignored
        if (tmo) state_d = cnv_lvl_i ? ST_IDLE : ST_SLEEP;
        else     cnt_d = cnt_q - 1'b1;
      end
      ST_SLEEP: if (cnv_rise_i) begin
        state_d = ST_WAKE;
        cnt_d   = WAKE_LAST;
        pend_d  = 1'b0;
      end
      ST_WAKE: begin
        if (cnv_fall_i) pend_d = 1'b1;
        if (tmo) begin
          pend_d = 1'b0;
          if (pend_q || cnv_fall_i) begin
            state_d  = ST_CONV;
            cnt_d    = CONV_LAST;
            hold_now = 1'b1;
          end else begin
            state_d = ST_IDLE;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      held_o  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
      if (hold_now) held_o <= sample_i;
    end
  end

  assign busy_o  = (state_q == ST_CONV) || (state_q == ST_WAKE && pend_q);
  assign sleep_o = (state_q == ST_SLEEP);
  assign load_o  = (state_q == ST_CONV) && tmo;
endmodule

// File: rtl/adc_port_shifter.sv
module adc_port_shifter #(
  parameter int SAMPLE_W = 12,
  parameter int WORD_W   = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [SAMPLE_W-1:0] data_i,
  input  logic                clr_i,
  input  logic                rise_i,
  input  logic                fall_i,
  output logic                sdo_o,
  output logic                oe_o
);
  localparam int LEAD = WORD_W - SAMPLE_W;
  localparam int PW   = $clog2(WORD_W);
  localparam logic [PW-1:0] POS_LAST = PW'(WORD_W - 1);

  logic [SAMPLE_W-1:0] data_q;
  logic [PW-1:0]       pos_q;
  logic                oe_q, wrap_q;
  logic [WORD_W-1:0]   word;
  logic [PW-1:0]       idx;

  assign word = {{LEAD{1'b0}}, data_q};
  assign idx  = POS_LAST - pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      pos_q  <= '0;
      oe_q   <= 1'b0;
      wrap_q <= 1'b0;
    end else begin
      if (load_i) data_q <= data_i;
      if (clr_i) begin
        pos_q  <= '0;
        oe_q   <= 1'b0;
        wrap_q <= 1'b0;
      end else if (rise_i && pos_q == '0) begin
        oe_q <= 1'b1;
      end else if (fall_i && oe_q) begin
        if (pos_q == POS_LAST) begin
          pos_q  <= '0;
          wrap_q <= 1'b1;
          if (!wrap_q) oe_q <= 1'b0;
        end else begin
          pos_q <= pos_q + 1'b1;
        end
      end
    end
  end

  assign oe_o  = oe_q;
  assign sdo_o = oe_q & word[idx];
endmodule

// File: rtl/adc_serial_port_model.sv
module adc_serial_port_model #(
  parameter int SAMPLE_W    = 12,
  parameter int WORD_W      = 16,
  parameter int CONV_CYCLES = 380,
  parameter int WAKE_CYCLES = 600
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cnv_i,
  input  logic                sclk_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic                busy_o,
  output logic                sdo_o,
  output logic                sdo_oe_o,
  output logic                sleep_o
);
  // lane 0: convert-start (idles high), lane 1: serial clock (idles low)
  logic [1:0] lvl, rise, fall;
  logic                load;
  logic [SAMPLE_W-1:0] held;

  adc_port_sync #(
    .WIDTH    (2),
    .RESET_VAL(2'b01)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({sclk_i, cnv_i}),
    .level_o(lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  adc_port_ctrl #(
    .SAMPLE_W   (SAMPLE_W),
    .CONV_CYCLES(CONV_CYCLES),
    .WAKE_CYCLES(WAKE_CYCLES)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnv_lvl_i (lvl[0]),
    .cnv_rise_i(rise[0]),
    .cnv_fall_i(fall[0]),
    .sample_i  (sample_i),
    .busy_o    (busy_o),
    .sleep_o   (sleep_o),
    .load_o    (load),
    .held_o    (held)
  );

  adc_port_shifter #(
    .SAMPLE_W(SAMPLE_W),
    .WORD_W  (WORD_W)
  ) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .data_i(held),
    .clr_i (fall[0] & ~lvl[1]),
    .rise_i(rise[1]),
    .fall_i(fall[1]),
    .sdo_o (sdo_o),
    .oe_o  (sdo_oe_o)
  );
endmodule

// File: rtl/adc_serial_port_model_chk.sv
module adc_serial_port_model_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cnv_i,
  input logic sclk_i,
  input logic busy_o,
  input logic sdo_oe_o,
  input logic sleep_o
);
  // R2, R9: busy only rises after convert-start was low two samples back
  p_busy_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !$past(cnv_i, 2));

  // R8: sleep is entered only as a conversion ends with convert-start low
  p_sleep_entry_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sleep_o) |-> ($fell(busy_o) && !$past(cnv_i, 2)));

  // R8: conversion ending with convert-start high stays awake
  p_no_sleep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && $past(cnv_i, 2)) |-> !sleep_o);

  // R9: leaving sleep follows a convert-start rise and is not busy yet
  p_wake_exit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sleep_o) |-> ($past(cnv_i, 2) && !busy_o));

  // R4, R6: the output enable turns on only after a serial clock rise
  p_oe_on_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_oe_o) |-> $past(sclk_i, 2));
endmodule

bind adc_serial_port_model adc_serial_port_model_chk chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cnv_i   (cnv_i),
  .sclk_i  (sclk_i),
  .busy_o  (busy_o),
  .sdo_oe_o(sdo_oe_o),
  .sleep_o (sleep_o)
);

// File: tb/adc_serial_port_model_tb_top.sv
module adc_serial_port_model_tb_top;
  localparam int C = 20;
  localparam int W = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnv = 1'b1;
  logic sclk = 1'b0;
  logic [11:0] sample = '0;
  logic busy, sdo, oe, sleep;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  adc_serial_port_model #(
    .SAMPLE_W(12), .WORD_W(16), .CONV_CYCLES(C), .WAKE_CYCLES(W)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cnv_i(cnv), .sclk_i(sclk),
    .sample_i(sample), .busy_o(busy), .sdo_o(sdo), .sdo_oe_o(oe),
    .sleep_o(sleep)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclk_up();
    sclk = 1'b1;
    tick(4);
  endtask

  task automatic sclk_dn();
    sclk = 1'b0;
    tick(4);
  endtask

  // R3 R4 R5 R6 R11: shift out a full word
  task automatic read_word(input logic [11:0] v, input bit wrapped, input string tag);
    logic [15:0] w;
    w = {4'b0000, v};
    sclk_up();
    chk(oe == 1'b1, {tag, " R4 oe after first rise"}, oe, 1);
    chk(sdo == w[15], {tag, " R3 bit15"}, sdo, w[15]);
    for (int k = 1; k < 16; k++) begin
      sclk_dn();
      chk(sdo == w[15-k] && oe, {tag, " R3 R4 bit"}, {oe, sdo}, {1'b1, w[15-k]});
      sclk_up();
    end
    sclk_dn();
    if (wrapped) chk(oe == 1'b1, {tag, " R6 oe held after wrap"}, oe, 1);
    else begin
      chk(oe == 1'b0, {tag, " R5 oe off after 16th fall"}, oe, 0);
      chk(sdo == 1'b0, {tag, " R5 sdo zero when off"}, sdo, 0);
    end
  endtask

  // R2 R8 R12: start a conversion from idle and time busy
  task automatic convert(input logic [11:0] v, input bit stay_low, input bit glitch,
                         input string tag);
    int first, cnt;
    bit seen;
    first = 0; cnt = 0; seen = 1'b0;
    sample = v;
    cnv = 1'b0;
    for (int k = 1; k < 200; k++) begin
      @(negedge clk);
      if (!stay_low && k == 2) cnv = 1'b1;
      if (glitch && k == 6) cnv = 1'b0;
      if (glitch && k == 10) cnv = 1'b1;
      if (busy) begin
        if (!seen) begin
          first = k;
          chk(oe == 1'b0, {tag, " R7 position cleared by fall with sclk low"}, oe, 0);
        end
        seen = 1'b1;
        cnt++;
      end else if (seen) break;
    end
    chk(first == 3, {tag, " R2 busy latency"}, first, 3);
    chk(cnt == C, {tag, glitch ? " R12 busy length with second fall" : " R2 busy length"}, cnt, C);
    chk(sleep == stay_low, {tag, " R8 sleep at end"}, sleep, stay_low);
  endtask

  initial begin
    int n;
    bit seen;
    tick(3);
    chk(busy == 0 && sleep == 0 && oe == 0 && sdo == 0, "R1 reset state",
        {busy, sleep, oe, sdo}, 0);
    rst_n = 1'b1;
    tick(4);

    // sweep over the sample range
    for (int i = 0; i < 64; i++) begin
      logic [11:0] v;
      v = 12'(i * 65);
      convert(v, 1'b0, 1'b0, "sweep");
      read_word(v, 1'b0, "sweep");
    end

    // R6: extra clocks restart and keep the line driven
    convert(12'hA5C, 1'b0, 1'b0, "wrap");
    read_word(12'hA5C, 1'b0, "wrap");
    read_word(12'hA5C, 1'b1, "wrap R6");
    tick(20);
    chk(oe == 1'b1, "R6 oe held after clock stops", oe, 1);

    // R7: fall with sclk low clears (checked inside convert)
    convert(12'h5A3, 1'b0, 1'b0, "clr");
    sclk_up();
    for (int k = 1; k <= 5; k++) begin
      sclk_dn();
      sclk_up();
    end
    // sclk high: this fall must not clear the position
    cnv = 1'b0;
    tick(3);
    cnv = 1'b1;
    tick(C + 10);
    chk(oe == 1'b1, "R7 oe kept when fall with sclk high", oe, 1);
    sclk_dn();
    chk(oe == 1'b1 && sdo == (16'h05A3 >> 9) % 2, "R7 position continues",
        {oe, sdo}, {1'b1, 1'(16'h05A3 >> 9)});

    // R12: second fall during conversion ignored
    convert(12'h3C7, 1'b0, 1'b1, "ignore");
    read_word(12'h3C7, 1'b0, "ignore R12");

    // R8 R11: sleep and read while asleep
    convert(12'hE19, 1'b1, 1'b0, "sleep");
    read_word(12'hE19, 1'b0, "asleep R11");
    chk(sleep == 1'b1, "R11 still asleep after read", sleep, 1);

    // R9: wake then convert with fall inside the wake period
    sample = 12'h6B2;
    cnv = 1'b1;
    n = 0; seen = 1'b0;
    for (int k = 1; k < 400; k++) begin
      @(negedge clk);
      if (k == 2) cnv = 1'b0;
      if (k == 4) chk(sleep == 1'b0, "R9 sleep cleared by rise", sleep, 0);
      if (busy) seen = 1'b1;
      else if (seen) begin n = k; break; end
    end
    chk(n == W + C + 3, "R9 wake plus conversion time", n, W + C + 3);
    chk(sleep == 1'b1, "R8 sleep again with cnv low", sleep, 1);
    read_word(12'h6B2, 1'b0, "wake R9");

    // R10: long high pulse, wake ends in idle
    cnv = 1'b1;
    tick(W + 15);
    chk(busy == 0 && sleep == 0, "R10 idle after wake with cnv high", {busy, sleep}, 0);
    convert(12'h0F1, 1'b0, 1'b0, "long R10");
    read_word(12'h0F1, 1'b0, "long R10");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule